// File: doc/BRIEF.md
# Transmit Byte Queue with Clear-to-Send Start Gating

This block sits between a host bus and a serial transmitter's shift register. The host pushes bytes into a 64-entry queue. The block presents the oldest byte to the serializer, along with a flag that says whether a byte is present. The serializer pulses a character-done input when it has shifted the last bit of that byte, and the byte then leaves the queue. An interrupt warns the host when the queue has drained to a programmable depth. The depth the host programs is held in reserve and only takes effect while an enhanced-mode input is high. Otherwise the depth is 8.

The remote receiver can throttle the link through an active-low clear-to-send pin. When automatic flow control is enabled, the pin is first brought into the clock domain through two flops. While the synchronized pin is high, the start-permit output is held low. This only stops the serializer from beginning a new character. A character already on the line still runs to its end and still pops its byte. A rising clear-to-send can raise a one-cycle change interrupt.

Top module: `txq_cts_gate`

## Requirements
- R1: Bytes leave the queue in the order written, and up to 64 are held. `q_data` shows the oldest stored byte, and `q_valid` is 1 exactly when at least one byte is stored.
- R2: A write (`wr_en`=1) while 64 bytes are stored is discarded, even if `char_done` is high in the same cycle. It sets `wr_ovf`, which then stays 1 until reset.
- R3: A `char_done` pulse removes the oldest byte when the queue is not empty. A pulse on an empty queue changes nothing. A write and a `char_done` in the same cycle on a non-full queue store the new byte and remove the oldest one, leaving the fill count unchanged.
- R4: `tx_irq` is 1 while the fill count is at or below the active trigger level, and 0 while it is above.
- R5: The active trigger level is 8 after reset and whenever `enh_en`=0. A `trig_we` pulse stores `trig_din` (a fill count, 0 to 64). The stored value becomes the active level only while `enh_en`=1.
- R6: `start_ok` is 1 when a byte is stored and flow control does not block. With `acts_en`=0, `cts_n` has no effect on `start_ok`.
- R7: With `acts_en`=1, `cts_n` is taken through two flops. A high `cts_n` drives `start_ok` to 0 after the second rising edge, and not after the first. A low `cts_n` lets `start_ok` return after the second edge. A `char_done` that arrives while blocked still removes its byte.
- R8: `cts_irq` pulses high for one cycle, in the same cycle the synchronized clear-to-send rises from 0 to 1, when `cts_ien`=1. There is no pulse when `cts_ien`=0, and no pulse on a fall.
- R9: During and right after reset, `q_valid`=0, `start_ok`=0, `tx_irq`=1, `cts_irq`=0 and `wr_ovf`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| trig_we | input | 1 | Store a new pending trigger level |
| trig_din | input | 7 | Pending trigger level, 0 to 64 |
| enh_en | input | 1 | Use the stored trigger level instead of 8 |
| acts_en | input | 1 | Enable automatic clear-to-send gating |
| cts_ien | input | 1 | Enable the clear-to-send change interrupt |
| cts_n | input | 1 | Active-low clear-to-send pin (asynchronous) |
| char_done | input | 1 | Serializer finished the current character |
| q_data | output | 8 | Oldest stored byte |
| q_valid | output | 1 | Queue holds at least one byte |
| start_ok | output | 1 | Serializer may begin a new character |
| tx_irq | output | 1 | Transmit trigger interrupt |
| cts_irq | output | 1 | One-cycle clear-to-send rise interrupt |
| wr_ovf | output | 1 | Sticky write-overflow flag |

## Verification
A host write and a serializer `char_done` can land in the same clock, which makes the write path and the pop path race on the same fill counter. The bench provokes this in two places. The first is just above the trigger level, where `tx_irq` must stay low. The second is with the queue full, where the write must be refused and `wr_ovf` set while the pop still goes through. In both cases it judges the outcome from the byte order seen by the scoreboard and from the final drain, which must end empty after exactly the predicted number of pops.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // trigger level used after reset and whenever enhanced mode is off
  localparam int unsigned TXQ_DEF_TRIG = 8;
endpackage

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pop_req,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [CW-1:0] cnt_nxt,
  output logic          ovf
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic full, wr_ok, pop_ok;

  assign full   = (cnt == CW'(DEPTH));
  assign wr_ok  = wr_en & ~full;
  assign pop_ok = pop_req & (cnt != '0);

  always_comb begin
    case ({wr_ok, pop_ok})
      2'b10:   cnt_nxt = cnt + CW'(1);
      2'b01:   cnt_nxt = cnt - CW'(1);
      default: cnt_nxt = cnt;
    endcase
  end

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (wr_ok)  wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (pop_ok) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      cnt <= cnt_nxt;
      if (wr_en && full) ovf <= 1'b1;
    end
  end

  assign rd_data  = mem[rp];
  assign rd_valid = (cnt != '0);

  // R1: fill count never exceeds the depth
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  // R2: a refused write never grows the count
  a_r2_full_no_grow: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> (cnt <= $past(cnt)));
  // R2: overflow flag is sticky
  a_r2_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  // R3: a pop on an empty queue leaves it holding at most the new write
  a_r3_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !rd_valid && !wr_en) |=> !rd_valid);
endmodule

// File: rtl/tx_trig_irq.sv
module tx_trig_irq #(
  parameter int CW       = 7,
  parameter int DEF_TRIG = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig_we,
  input  logic [CW-1:0] trig_din,
  input  logic          enh_en,
  input  logic [CW-1:0] cnt_nxt,
  output logic          irq
);
  logic [CW-1:0] trig_q, act;

  assign act = enh_en ? trig_q : CW'(DEF_TRIG);

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= CW'(DEF_TRIG);
      irq    <= 1'b1;
    end else begin
      if (trig_we) trig_q <= trig_din;
      irq <= (cnt_nxt <= act);
    end
  end

  // R4: an empty queue always raises the interrupt
  a_r4_empty_irq: assert property (@(posedge clk) disable iff (rst)
    (cnt_nxt == '0) |=> irq);
  // R5: with enhanced mode off the level is the default
  a_r5_default_level: assert property (@(posedge clk) disable iff (rst)
    (!enh_en && cnt_nxt > CW'(DEF_TRIG)) |=> !irq);
endmodule

// File: rtl/cts_gate.sv
module cts_gate (
  input  logic clk,
  input  logic rst,
  input  logic cts_n,
  input  logic acts_en,
  input  logic cts_ien,
  input  logic have_data,
  output logic start_ok,
  output logic cts_irq
);
  logic s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= 1'b0;
      s2      <= 1'b0;
      cts_irq <= 1'b0;
    end else begin
      s1      <= cts_n;
      s2      <= s1;
      cts_irq <= cts_ien & s1 & ~s2;
    end
  end

  // only the start of a character is blocked; a running frame is untouched
  assign start_ok = have_data & ~(acts_en & s2);

  // R8: the change interrupt is a single-cycle pulse
  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    cts_irq |=> !cts_irq);
  // R7: a pin held high two edges ago blocks starts under flow control
  a_r7_block: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(cts_n, 2) && acts_en) |-> !start_ok);
  // R6: no data, no start
  a_r6_need_data: assert property (@(posedge clk) disable iff (rst)
    !have_data |-> !start_ok);
endmodule

// File: rtl/txq_cts_gate.sv
module txq_cts_gate #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          trig_we,
  input  logic [CW-1:0] trig_din,
  input  logic          enh_en,
  input  logic          acts_en,
  input  logic          cts_ien,
  input  logic          cts_n,
  input  logic          char_done,
  output logic [DW-1:0] q_data,
  output logic          q_valid,
  output logic          start_ok,
  output logic          tx_irq,
  output logic          cts_irq,
  output logic          wr_ovf
);
  logic [CW-1:0] cnt_nxt;

  tx_byte_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pop_req(char_done), .rd_data(q_data), .rd_valid(q_valid),
    .cnt_nxt(cnt_nxt), .ovf(wr_ovf)
  );

  tx_trig_irq #(.CW(CW), .DEF_TRIG(txq_pkg::TXQ_DEF_TRIG)) u_trig (
    .clk(clk), .rst(rst), .trig_we(trig_we), .trig_din(trig_din),
    .enh_en(enh_en), .cnt_nxt(cnt_nxt), .irq(tx_irq)
  );

  cts_gate u_gate (
    .clk(clk), .rst(rst), .cts_n(cts_n), .acts_en(acts_en),
    .cts_ien(cts_ien), .have_data(q_valid), .start_ok(start_ok),
    .cts_irq(cts_irq)
  );
endmodule

// File: tb/tb_txq_cts_gate.sv
`timescale 1ns/1ps
module tb_txq_cts_gate;
  logic clk = 0, rst = 1;
  logic wr_en = 0, trig_we = 0, enh_en = 0, acts_en = 0, cts_ien = 0;
  logic cts_n = 0, char_done = 0;
  logic [7:0] wr_data = 0;
  logic [6:0] trig_din = 0;
  logic [7:0] q_data;
  logic q_valid, start_ok, tx_irq, cts_irq, wr_ovf;

  int checks = 0, errors = 0, mcount = 0, hits;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  txq_cts_gate dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .trig_we(trig_we), .trig_din(trig_din), .enh_en(enh_en),
    .acts_en(acts_en), .cts_ien(cts_ien), .cts_n(cts_n),
    .char_done(char_done), .q_data(q_data), .q_valid(q_valid),
    .start_ok(start_ok), .tx_irq(tx_irq), .cts_irq(cts_irq), .wr_ovf(wr_ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compares each byte the serializer consumes with the scoreboard
  always @(negedge clk) begin
    if (!rst && char_done && q_valid) begin
      if (exp_q.size() == 0) chk("R1 unexpected byte", q_data, -1);
      else chk("R1 byte order", q_data, exp_q.pop_front());
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] b);
    step(); wr_en = 1; wr_data = b;
    if (mcount < 64) begin exp_q.push_back(b); mcount++; end
    step(); wr_en = 0;
  endtask

  task automatic pop();
    step(); char_done = 1;
    if (mcount > 0) mcount--;
    step(); char_done = 0;
  endtask

  task automatic wr_pop(input logic [7:0] b);
    step(); wr_en = 1; wr_data = b; char_done = 1;
    if (mcount == 0) begin exp_q.push_back(b); mcount++; end
    else if (mcount < 64) exp_q.push_back(b);
    else mcount--;
    step(); wr_en = 0; char_done = 0;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    at_neg();
    chk("R9 q_valid in reset", q_valid, 0);
    chk("R9 tx_irq in reset", tx_irq, 1);
    rst = 0;
    step(); at_neg();
    chk("R9 q_valid", q_valid, 0);
    chk("R9 start_ok", start_ok, 0);
    chk("R9 tx_irq", tx_irq, 1);
    chk("R9 cts_irq", cts_irq, 0);
    chk("R9 wr_ovf", wr_ovf, 0);

    for (int i = 0; i < 8; i++) wr(8'hA0 + 8'(i));
    at_neg();
    chk("R1 q_valid", q_valid, 1);
    chk("R1 head", q_data, 8'hA0);
    chk("R6 start_ok cts ignored", start_ok, 1);
    chk("R4 irq at level 8", tx_irq, 1);
    wr(8'hA8);
    at_neg();
    chk("R4 irq above level", tx_irq, 0);
    wr_pop(8'hA9);
    at_neg();
    chk("R3 simultaneous wr+pop keeps count", tx_irq, 0);

    step(); trig_we = 1; trig_din = 7'd16; step(); trig_we = 0;
    repeat (2) step(); at_neg();
    chk("R5 stored level unused", tx_irq, 0);
    enh_en = 1; repeat (2) step(); at_neg();
    chk("R5 stored level active", tx_irq, 1);
    enh_en = 0; repeat (2) step(); at_neg();
    chk("R5 back to default", tx_irq, 0);

    while (mcount > 0) pop();
    at_neg();
    chk("R3 drained", q_valid, 0);
    pop();
    wr(8'h5C);
    at_neg();
    chk("R3 empty pop ignored", q_data, 8'h5C);
    pop();
    at_neg();
    chk("R3 single pop empties", q_valid, 0);

    for (int i = 0; i < 64; i++) wr(8'(i * 3 + 1));
    at_neg();
    chk("R1 64 held no ovf", wr_ovf, 0);
    wr(8'hEE);
    at_neg();
    chk("R2 ovf set", wr_ovf, 1);
    wr_pop(8'hEF);
    at_neg();
    chk("R2 ovf sticky", wr_ovf, 1);

    // CTS gating with data present
    cts_n = 1; hits = 0;
    for (int i = 0; i < 5; i++) begin step(); at_neg(); hits += int'(cts_irq); end
    chk("R8 no pulse when disabled", hits, 0);
    chk("R6 acts off ignores cts", start_ok, 1);
    acts_en = 1; at_neg();
    chk("R7 blocked", start_ok, 0);
    pop();
    cts_n = 0; repeat (3) step();
    cts_ien = 1;
    at_neg();
    chk("R7 resumed", start_ok, 1);
    step(); cts_n = 1;
    at_neg();
    step(); at_neg();
    chk("R7 not blocked after 1 edge", start_ok, 1);
    chk("R8 no pulse yet", cts_irq, 0);
    step(); at_neg();
    chk("R7 blocked after 2 edges", start_ok, 0);
    chk("R8 pulse", cts_irq, 1);
    step(); at_neg();
    chk("R8 single cycle", cts_irq, 0);
    pop();
    at_neg();
    chk("R7 pop while blocked", start_ok, 0);
    step(); cts_n = 0; hits = 0;
    at_neg();
    step(); at_neg(); hits += int'(cts_irq);
    chk("R7 still blocked after 1 edge", start_ok, 0);
    step(); at_neg(); hits += int'(cts_irq);
    chk("R7 resume after 2 edges", start_ok, 1);
    step(); at_neg(); hits += int'(cts_irq);
    chk("R8 no pulse on fall", hits, 0);

    while (mcount > 0) pop();
    at_neg();
    chk("R2 refused writes absent", q_valid, 0);
    chk("R2 scoreboard empty", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule